// File: doc/BRIEF.md
# Switch Input Port Request Controller

This block serves one input port of a switch that buffers cells both before and after its crossbar. Fixed-size cells arrive together with a tag naming the output port they are bound for, and they wait in a single first-in first-out store. In every time slot the controller looks only at the oldest stored cell. If a cell is present, it raises exactly one request line, the one belonging to that cell's output port, toward that port's scheduler.

The cell stays at the head until an acknowledge comes back. When the acknowledge arrives, the controller removes the cell and presents it to the crossbar for one cycle, together with the index of the internal link that was granted. A cell stuck at the head holds back every cell behind it, even cells bound for idle outputs. That head-of-line behaviour is intended.

The write side is a valid/ready stream. `in_ready` is high whenever the store has a free slot, and a cell is taken on any cycle in which `in_valid` and `in_ready` are both high. A writer that ignores back-pressure loses data: a cell offered while `in_ready` is low is discarded and counted. A write and a removal in the same cycle are both carried out. The request, acknowledge and crossbar-side pins are plain level signals with no handshake.

Top module: `sw_inport_ctrl`

## Requirements
- R1: After reset, `req_vec` is all zero, `out_valid` is 0, `in_ready` is 1 and `drop_count` is 0.
- R2: `req_vec` has at most one bit set. While the store holds a cell, the set bit is bit k, where k is the destination tag of the oldest cell. While the store is empty, `req_vec` is zero.
- R3: Cells leave in the order in which they were accepted. Each cell leaves with its own destination tag on `out_dest`.
- R4: If `ack` is high in a cycle where a request is raised, then in the next cycle `out_valid` is 1. In that cycle `out_cell` and `out_dest` carry the cell that was at the head, and `out_link` equals the `ack_link` value sampled with the acknowledge.
- R5: Without `ack`, the head cell stays in place. `req_vec` keeps the same value in the next cycle and `out_valid` stays 0. A later cell bound for a different output raises no request while it is behind the head.
- R6: `ack` while the store is empty has no effect. `out_valid` stays 0 in the next cycle and `req_vec` stays zero.
- R7: When a write is accepted in the same cycle that `ack` removes the head, both take effect. The removed cell appears on the output, and the written cell becomes the next head.
- R8: `in_ready` is 0 exactly while DEPTH cells are stored. A cell offered while `in_ready` is 0 is never stored and never appears on the output, and it increments `drop_count` by one.
- R9: `drop_count` saturates at 2^DROP_W-1 and stays there under further dropped writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Writer offers a cell |
| in_ready | output | 1 | Store has room; cell accepted when valid and ready |
| in_cell | input | CELL_W | Cell payload |
| in_dest | input | clog2(N_PORTS) | Destination output port of the offered cell |
| req_vec | output | N_PORTS | One-hot request toward the output schedulers |
| ack | input | 1 | Grant for this input in the current slot |
| ack_link | input | clog2(N_LINKS) | Internal link index granted |
| out_valid | output | 1 | Cell presented to the crossbar this cycle |
| out_cell | output | CELL_W | Payload of the forwarded cell |
| out_dest | output | clog2(N_PORTS) | Destination of the forwarded cell |
| out_link | output | clog2(N_LINKS) | Link on which the cell is forwarded |
| drop_count | output | DROP_W | Saturating count of discarded writes |

## Verification
The hardest state to reach from the ports is the saturated drop counter. It needs the store held full while more than 2^DROP_W-1 further cells are offered against a low `in_ready`. The stimulus fills the store, then keeps `in_valid` high for several hundred slots with no acknowledge, and reads the counter at three points: after a few drops, and at and beyond the ceiling. It then drains the whole store and confirms that none of the refused cells surfaces. A second hard case is a write that coincides with a removal while exactly one cell is stored. The bench builds it by parking a single cell, then raising `in_valid` and `ack` in the same slot.

// File: rtl/sw_inport_pkg.sv
package sw_inport_pkg;
  // Width of an index into n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/inport_cell_fifo.sv
module inport_cell_fifo
  import sw_inport_pkg::*;
#(
  parameter int ENT_W = 18,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] wdata,
  input  logic             pop,
  output logic [ENT_W-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;

  wire do_push = push && (fill != CAP);
  wire do_pop  = pop  && (fill != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CAP);
endmodule

// File: rtl/inport_req_decode.sv
module inport_req_decode #(
  parameter int N_PORTS = 4,
  parameter int DEST_W  = 2
) (
  input  logic              head_ok,
  input  logic [DEST_W-1:0] head_dest,
  output logic [N_PORTS-1:0] req_vec
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_req
    assign req_vec[p] = head_ok && (head_dest == DEST_W'(p));
  end
endmodule

// File: rtl/inport_sat_counter.sv
module inport_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     value <= '0;
    else if (bump && value != '1)   value <= value + 1'b1;
  end
endmodule

// File: rtl/sw_inport_ctrl.sv
module sw_inport_ctrl
  import sw_inport_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DEPTH   = 8,
  parameter int CELL_W  = 16,
  parameter int N_LINKS = 2,
  parameter int DROP_W  = 8,
  localparam int DEST_W = idx_w(N_PORTS),
  localparam int LINK_W = idx_w(N_LINKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CELL_W-1:0]  in_cell,
  input  logic [DEST_W-1:0]  in_dest,
  output logic [N_PORTS-1:0] req_vec,
  input  logic               ack,
  input  logic [LINK_W-1:0]  ack_link,
  output logic               out_valid,
  output logic [CELL_W-1:0]  out_cell,
  output logic [DEST_W-1:0]  out_dest,
  output logic [LINK_W-1:0]  out_link,
  output logic [DROP_W-1:0]  drop_count
);
  localparam int ENT_W = DEST_W + CELL_W;

  logic              q_empty, q_full;
  logic [ENT_W-1:0]  head;
  logic [DEST_W-1:0] head_dest;
  logic [CELL_W-1:0] head_cell;

  wire take    = in_valid && !q_full;
  wire refuse  = in_valid && q_full;
  wire release_head = ack && !q_empty;

  assign {head_dest, head_cell} = head;
  assign in_ready = !q_full;

  inport_cell_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .wdata ({in_dest, in_cell}),
    .pop   (release_head),
    .rdata (head),
    .empty (q_empty),
    .full  (q_full)
  );

  inport_req_decode #(.N_PORTS(N_PORTS), .DEST_W(DEST_W)) u_req (
    .head_ok   (!q_empty),
    .head_dest (head_dest),
    .req_vec   (req_vec)
  );

  inport_sat_counter #(.W(DROP_W)) u_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (refuse),
    .value (drop_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cell  <= '0;
      out_dest  <= '0;
      out_link  <= '0;
    end else begin
      out_valid <= release_head;
      if (release_head) begin
        out_cell <= head_cell;
        out_dest <= head_dest;
        out_link <= ack_link;
      end
    end
  end
endmodule

// File: rtl/sw_inport_ctrl_chk.sv
module sw_inport_ctrl_chk #(
  parameter int N_PORTS = 4,
  parameter int DEST_W  = 2,
  parameter int LINK_W  = 1,
  parameter int DROP_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [N_PORTS-1:0] req_vec,
  input logic               ack,
  input logic [LINK_W-1:0]  ack_link,
  input logic               out_valid,
  input logic [LINK_W-1:0]  out_link,
  input logic [DROP_W-1:0]  drop_count
);
  localparam logic [DROP_W-1:0] TOP = '1;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec));
  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_vec != '0) |=> out_valid);
  a_r4_link: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_vec != '0) |=> (out_link == $past(ack_link)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && req_vec != '0) |=> ($stable(req_vec) && !out_valid));
  a_r6_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec == '0) |=> !out_valid);
  a_r8_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && drop_count != TOP) |=> (drop_count == $past(drop_count) + 1'b1));
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == TOP) |=> (drop_count == TOP));
endmodule

bind sw_inport_ctrl sw_inport_ctrl_chk #(
  .N_PORTS(N_PORTS), .DEST_W(DEST_W), .LINK_W(LINK_W), .DROP_W(DROP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .req_vec    (req_vec),
  .ack        (ack),
  .ack_link   (ack_link),
  .out_valid  (out_valid),
  .out_link   (out_link),
  .drop_count (drop_count)
);

// File: tb/sw_inport_ctrl_test.sv
`timescale 1ns/1ps
module sw_inport_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_cell = '0;
  logic [1:0]  in_dest = '0;
  logic [3:0]  req_vec;
  logic        ack = 1'b0;
  logic [0:0]  ack_link = '0;
  logic        out_valid;
  logic [15:0] out_cell;
  logic [1:0]  out_dest;
  logic [0:0]  out_link;
  logic [7:0]  drop_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sw_inport_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cell(in_cell), .in_dest(in_dest), .req_vec(req_vec), .ack(ack),
    .ack_link(ack_link), .out_valid(out_valid), .out_cell(out_cell),
    .out_dest(out_dest), .out_link(out_link), .drop_count(drop_count)
  );

  // Entry layout: [18:17] destination, [16] granted link, [15:0] cell.
  localparam logic [18:0] VEC [8] = '{
    {2'd2, 1'b1, 16'hA001}, {2'd0, 1'b0, 16'hA002},
    {2'd3, 1'b0, 16'hA003}, {2'd1, 1'b1, 16'hA004},
    {2'd1, 1'b1, 16'hA005}, {2'd2, 1'b0, 16'hA006},
    {2'd0, 1'b1, 16'hA007}, {2'd3, 1'b0, 16'hA008}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [1:0] d, input logic [15:0] c);
    in_valid = 1'b1; in_dest = d; in_cell = c;
    step();
    in_valid = 1'b0;
  endtask

  // Grant the head and check the forwarded cell one cycle later.
  task automatic grant(input logic [0:0] l, input logic [1:0] d, input logic [15:0] c, input string tag);
    chk(req_vec == (4'b1 << d), {tag, " request"}, req_vec, 4'b1 << d);
    ack = 1'b1; ack_link = l;
    step();
    ack = 1'b0;
    chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_cell == c && out_dest == d, {tag, " cell"}, {out_dest, out_cell}, {d, c});
    chk(out_link == l, {tag, " link"}, out_link, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk(req_vec == 4'b0 && out_valid == 1'b0, "R1 outputs idle", {req_vec, out_valid}, 0);
    chk(in_ready == 1'b1 && drop_count == 8'd0, "R1 ready and count", {in_ready, drop_count}, 9'h100);
    rst_n = 1'b1;
    step();

    // Table walk: fill, then grant in order (R2, R3, R4)
    for (int i = 0; i < 8; i++) push(VEC[i][18:17], VEC[i][15:0]);
    chk(in_ready == 1'b0, "R8 ready low when full", in_ready, 0);
    for (int i = 0; i < 8; i++) grant(VEC[i][16], VEC[i][18:17], VEC[i][15:0], "R3 R4 table");
    chk(req_vec == 4'b0, "R2 empty gives no request", req_vec, 0);
    step();
    chk(out_valid == 1'b0, "R4 valid is a single pulse", out_valid, 0);

    // R6 acknowledge while empty
    ack = 1'b1; ack_link = 1'b1;
    step();
    ack = 1'b0;
    chk(out_valid == 1'b0 && req_vec == 4'b0, "R6 empty ack ignored", {req_vec, out_valid}, 0);

    // R5 head-of-line blocking
    push(2'd1, 16'hB001);
    push(2'd2, 16'hB002);
    for (int i = 0; i < 3; i++) begin
      chk(req_vec == 4'b0010, "R5 head keeps requesting", req_vec, 4'b0010);
      step();
      chk(out_valid == 1'b0, "R5 no forward without ack", out_valid, 0);
    end
    grant(1'b0, 2'd1, 16'hB001, "R5 blocked head");
    grant(1'b1, 2'd2, 16'hB002, "R5 follower");

    // R7 write and removal together with one cell stored
    push(2'd3, 16'hC001);
    in_valid = 1'b1; in_dest = 2'd0; in_cell = 16'hC002;
    ack = 1'b1; ack_link = 1'b1;
    step();
    in_valid = 1'b0; ack = 1'b0;
    chk(out_valid && out_cell == 16'hC001, "R7 removed cell out", out_cell, 16'hC001);
    chk(req_vec == 4'b0001, "R7 written cell is new head", req_vec, 4'b0001);
    grant(1'b0, 2'd0, 16'hC002, "R7 written cell");
    chk(req_vec == 4'b0, "R7 store empty after", req_vec, 0);

    // R8 overflow and R9 saturation
    for (int i = 0; i < 8; i++) push(2'(i), 16'hD000 + 16'(i));
    in_valid = 1'b1; in_dest = 2'd3; in_cell = 16'hDEAD;
    repeat (3) step();
    chk(drop_count == 8'd3, "R8 drops counted", drop_count, 3);
    repeat (252) step();
    chk(drop_count == 8'd255, "R9 reaches ceiling", drop_count, 255);
    repeat (40) step();
    in_valid = 1'b0;
    chk(drop_count == 8'd255, "R9 holds ceiling", drop_count, 255);
    for (int i = 0; i < 8; i++) grant(1'(i), 2'(i), 16'hD000 + 16'(i), "R8 refused cell absent");
    chk(req_vec == 4'b0, "R8 nothing extra stored", req_vec, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule